// File: doc/BRIEF.md
# Word-Mark-Aware Output Character Fetch

This block feeds an output device with characters taken from a seven-bit, word-marked character memory. Bit 6 of a stored character is its word mark and bits 5:0 are its value. The block answers one character request at a time. Each answer carries a response code and, when the code is OK, a data character. The code values are OK (2'b00), END (2'b01) and TERR (2'b10). A new command loads a start address and a mode set and makes the block active. Each request then walks the address upward until an end condition stops the transfer.

There are four modes:
- **Move mode** sends each stored character, word mark included, unless six-bit mode strips bit 6.
- **Load mode** turns each word-marked character, and each character equal to the separator 7'h1D, into two device characters: the separator first, then the bare six-bit value on the next request. A one-character hold register carries that value between the two requests.
- **Record mode** (the default, as opposed to no-record mode) stops at the group mark 7'h7F.
- **Disk command phase** sends six-bit characters up to a group mark, without consuming it.

The memory read port is combinational. The response to a request captured at a clock edge is presented right after that edge, for one cycle.

Top module: `fch_out_fetch`

## Requirements
- R1: After reset, rsp_valid, active_o and done_o are 0.
- R2: A request not coincident with cmd_go yields exactly one rsp_valid pulse in the following cycle; without a request rsp_valid stays 0.
- R3: A request with req_weor set returns END and sets done_o, whatever the block's state.
- R4: A request while inactive (and without req_weor) returns TERR and leaves the address unchanged.
- R5: In the disk command phase, each request returns the memory character with bit 6 cleared and advances the address. A group mark returns END, leaves the address on it and keeps active_o set.
- R6: A request that fetches from the last memory address (MEM_WORDS-1) returns END without sending it, clears active_o and advances the address to MEM_WORDS.
- R7: In record mode, fetching 7'h7F returns END, clears active_o, sets done_o and leaves the address just past it. In no-record mode, 7'h7F is sent as data.
- R8: In load mode, a fetched character that is word-marked or equals 7'h1D is answered with 7'h1D. Its six-bit value is returned on the next request without a memory fetch.
- R9: A request with req_reor returns END with rsp_data 0, clears active_o and sets done_o. If it fetched from memory, the address advances past that character.
- R10: In move mode without six-bit, the stored character is returned unchanged, word mark included.
- R11: Accepting a new command discards a held load-mode character.
- R12: With six-bit mode, returned move-mode characters have bit 6 cleared.
- R13: Any non-OK response carries rsp_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Accept a new command |
| cmd_addr | input | AW | Start address of the command |
| cmd_load | input | 1 | Load mode (word marks expanded) |
| cmd_norec | input | 1 | No-record mode (group mark is data) |
| cmd_sixbit | input | 1 | Strip bit 6 of move-mode characters |
| cmd_disk | input | 1 | Disk command phase |
| req | input | 1 | Device character request |
| req_weor | input | 1 | Request carries write-end flag |
| req_reor | input | 1 | Request carries device end-of-record |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 7 | Memory character at mem_addr (bit 6 word mark) |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 2 | 00 OK, 01 END, 10 TERR |
| rsp_data | output | 7 | Character for the device |
| active_o | output | 1 | Transfer active |
| done_o | output | 1 | Transfer done |
| addr_o | output | AW | Current address |

## Verification
Every result is due one register stage after the request: the response and the updated active, done and address state all appear right after the clock edge that captured the request. The driver changes inputs on the falling edge and pushes the expected response into a queue. The monitor samples one nanosecond after each rising edge, so it sees each response in the cycle the requirements place it. A missing strobe while an item is queued, or a strobe with an empty queue, counts as a failure. Status checks are taken at the falling edge that ends each request.

// File: rtl/fch_pkg.sv
package fch_pkg;

    localparam int CW = 7;
    localparam logic [CW-1:0] SEP_CHAR   = 7'h1D;
    localparam logic [CW-1:0] GROUP_MARK = 7'h7F;

    typedef enum logic [1:0] {
        RSP_OK   = 2'b00,
        RSP_END  = 2'b01,
        RSP_TERR = 2'b10
    } rsp_e;

    typedef struct packed {
        logic load;
        logic norec;
        logic sixbit;
        logic disk;
    } mode_t;

    typedef struct packed {
        rsp_e          code;
        logic [CW-1:0] data;
        logic          adv;
        logic          drop_active;
        logic          raise_done;
        logic          hold_set;
        logic          hold_clr;
        logic [5:0]    hold_val;
    } step_t;

    function automatic logic [CW-1:0] bare(input logic [CW-1:0] c);
        return {1'b0, c[5:0]};
    endfunction

    function automatic logic has_wm(input logic [CW-1:0] c);
        return c[6];
    endfunction

    function automatic logic is_gm(input logic [CW-1:0] c);
        return c == GROUP_MARK;
    endfunction

endpackage

// File: rtl/fch_ctrl.sv
module fch_ctrl
    import fch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_go,
    input  mode_t cmd_mode,
    input  logic  take,
    input  step_t step,
    output logic  active,
    output logic  done,
    output mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            mode   <= '0;
        end else if (cmd_go) begin
            active <= 1'b1;
            done   <= 1'b0;
            mode   <= cmd_mode;
        end else if (take) begin
            if (step.drop_active) active <= 1'b0;
            if (step.raise_done)  done   <= 1'b1;
        end
    end
endmodule

// File: rtl/fch_addr.sv
module fch_addr #(
    parameter int MEM_WORDS = 512,
    parameter int AW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_go,
    input  logic [AW-1:0] cmd_addr,
    input  logic          bump,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(MEM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst)         addr <= '0;
        else if (cmd_go) addr <= cmd_addr;
        else if (bump)   addr <= addr + AW'(1);
    end

    assign at_last = (addr >= LAST_ADDR);
endmodule

// File: rtl/fch_hold.sv
module fch_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_go,
    input  logic       take,
    input  logic       set,
    input  logic       clr,
    input  logic [5:0] val,
    output logic       pend,
    output logic [5:0] held
);
    always_ff @(posedge clk) begin
        if (rst || cmd_go) begin
            pend <= 1'b0;
            held <= '0;
        end else if (take) begin
            if (set) begin
                pend <= 1'b1;
                held <= val;
            end else if (clr) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fch_decide.sv
module fch_decide
    import fch_pkg::*;
(
    input  logic          active,
    input  mode_t         mode,
    input  logic          pend,
    input  logic [5:0]    held,
    input  logic          at_last,
    input  logic [CW-1:0] rd,
    input  logic          weor,
    input  logic          reor,
    output step_t         step
);
    logic [CW-1:0] ch;
    logic          stop;

    always_comb begin
        step = '0;
        step.code = RSP_OK;
        ch   = '0;
        stop = 1'b0;
        if (weor) begin
            step.code       = RSP_END;
            step.raise_done = 1'b1;
        end else if (!active) begin
            step.code = RSP_TERR;
        end else if (mode.disk) begin
            if (is_gm(rd)) begin
                step.code = RSP_END;
            end else begin
                step.data = bare(rd);
                step.adv  = 1'b1;
            end
        end else begin
            if (pend) begin
                ch            = {1'b0, held};
                step.hold_clr = 1'b1;
            end else if (at_last) begin
                step.code        = RSP_END;
                step.drop_active = 1'b1;
                step.adv         = 1'b1;
                stop             = 1'b1;
            end else begin
                step.adv = 1'b1;
                if (!mode.norec && is_gm(rd)) begin
                    step.code        = RSP_END;
                    step.drop_active = 1'b1;
                    step.raise_done  = 1'b1;
                    stop             = 1'b1;
                end else if (mode.load && (has_wm(rd) || rd == SEP_CHAR)) begin
                    step.hold_set = 1'b1;
                    step.hold_val = rd[5:0];
                    step.data     = SEP_CHAR;
                    stop          = 1'b1;
                end else begin
                    ch = mode.sixbit ? bare(rd) : rd;
                end
            end
            if (!stop) begin
                if (reor) begin
                    step.code        = RSP_END;
                    step.drop_active = 1'b1;
                    step.raise_done  = 1'b1;
                end else begin
                    step.data = ch;
                end
            end
        end
    end
endmodule

// File: rtl/fch_out_fetch.sv
module fch_out_fetch
    import fch_pkg::*;
#(
    parameter int MEM_WORDS = 512,
    parameter int AW        = $clog2(MEM_WORDS + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_go,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_load,
    input  logic          cmd_norec,
    input  logic          cmd_sixbit,
    input  logic          cmd_disk,
    input  logic          req,
    input  logic          req_weor,
    input  logic          req_reor,
    output logic [AW-1:0] mem_addr,
    input  logic [6:0]    mem_rdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [6:0]    rsp_data,
    output logic          active_o,
    output logic          done_o,
    output logic [AW-1:0] addr_o
);
    mode_t         cmd_mode;
    mode_t         mode;
    step_t         step;
    logic          take;
    logic          active;
    logic          done;
    logic          pend;
    logic [5:0]    held;
    logic [AW-1:0] addr;
    logic          at_last;

    assign cmd_mode = '{load: cmd_load, norec: cmd_norec,
                        sixbit: cmd_sixbit, disk: cmd_disk};
    assign take = req && !cmd_go;

    fch_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_mode(cmd_mode),
        .take(take), .step(step), .active(active), .done(done), .mode(mode)
    );

    fch_addr #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_addr (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_addr(cmd_addr),
        .bump(take && step.adv), .addr(addr), .at_last(at_last)
    );

    fch_hold u_hold (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .take(take),
        .set(step.hold_set), .clr(step.hold_clr), .val(step.hold_val),
        .pend(pend), .held(held)
    );

    fch_decide u_decide (
        .active(active), .mode(mode), .pend(pend), .held(held),
        .at_last(at_last), .rd(mem_rdata), .weor(req_weor),
        .reor(req_reor), .step(step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_code <= step.code;
                rsp_data <= step.data;
            end
        end
    end

    assign mem_addr = addr;
    assign addr_o   = addr;
    assign active_o = active;
    assign done_o   = done;
endmodule

// File: rtl/fch_out_fetch_chk.sv
module fch_out_fetch_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_go,
    input logic          req,
    input logic          req_weor,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code,
    input logic [6:0]    rsp_data,
    input logic          active_o,
    input logic          done_o,
    input logic [AW-1:0] addr_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !active_o && !done_o));

    assert_one_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        (req && !cmd_go) |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !(req && !cmd_go) |=> !rsp_valid);

    assert_weor_end_R3: assert property (@(posedge clk) disable iff (rst)
        (req && !cmd_go && req_weor) |=> (rsp_code == 2'b01 && done_o));

    assert_idle_terr_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !cmd_go && !req_weor && !active_o) |=> (rsp_code == 2'b10 && $stable(addr_o)));

    assert_nodata_on_end_R13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'b00) |-> rsp_data == 7'h00);

    assert_active_drop_by_req_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> $past(req));
endmodule

bind fch_out_fetch fch_out_fetch_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .req(req), .req_weor(req_weor),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .active_o(active_o), .done_o(done_o), .addr_o(addr_o)
);

// File: tb/tb_fch_out_fetch.sv
`timescale 1ns/1ps
module tb_fch_out_fetch;
    localparam int MW = 512;
    localparam int AW = $clog2(MW + 2);

    typedef struct {
        logic [1:0] code;
        logic [6:0] data;
        string      tag;
    } exp_t;

    logic clk = 0, rst = 1;
    logic cmd_go = 0, cmd_load = 0, cmd_norec = 0, cmd_sixbit = 0, cmd_disk = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic req = 0, req_weor = 0, req_reor = 0;
    logic [AW-1:0] mem_addr, addr_o;
    logic [6:0] mem_rdata, rsp_data;
    logic [1:0] rsp_code;
    logic rsp_valid, active_o, done_o;
    logic [6:0] mem [MW];
    exp_t q[$];
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign mem_rdata = (int'(mem_addr) < MW) ? mem[mem_addr] : 7'h00;

    fch_out_fetch #(.MEM_WORDS(MW)) dut (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_addr(cmd_addr),
        .cmd_load(cmd_load), .cmd_norec(cmd_norec), .cmd_sixbit(cmd_sixbit),
        .cmd_disk(cmd_disk), .req(req), .req_weor(req_weor), .req_reor(req_reor),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_data(rsp_data), .active_o(active_o),
        .done_o(done_o), .addr_o(addr_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: one response per queued item, due right after the capturing edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    check(0, "R2 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rsp_code == e.code, {e.tag, " code"}, rsp_code, e.code);
                    check(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
                end
            end else if (q.size() != 0) begin
                check(0, "R2 missing strobe", 0, 1);
                void'(q.pop_front());
            end
        end
    end

    task automatic issue(input int a, input bit ld, input bit nr, input bit sb, input bit dk);
        @(negedge clk);
        cmd_go = 1; cmd_addr = AW'(a); cmd_load = ld; cmd_norec = nr;
        cmd_sixbit = sb; cmd_disk = dk;
        @(negedge clk);
        cmd_go = 0;
    endtask

    task automatic ask(input bit we, input bit re, input logic [1:0] c,
                       input logic [6:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1; req_weor = we; req_reor = re;
        e.code = c; e.data = d; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        req = 0; req_weor = 0; req_reor = 0;
    endtask

    task automatic status(input bit act, input bit dn, input int a, input string tag);
        check(active_o == act, {tag, " active"}, active_o, act);
        check(done_o == dn, {tag, " done"}, done_o, dn);
        check(int'(addr_o) == a, {tag, " addr"}, addr_o, a);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MW; i++) mem[i] = 7'h00;
        mem[10] = 7'h41; mem[11] = 7'h05; mem[12] = 7'h7F;
        mem[20] = 7'h47;
        mem[30] = 7'h7F;
        mem[40] = 7'h52; mem[41] = 7'h1D; mem[42] = 7'h03; mem[43] = 7'h7F;
        mem[50] = 7'h45; mem[51] = 7'h07; mem[52] = 7'h7F;
        mem[70] = 7'h09;
        mem[510] = 7'h11;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
        status(0, 0, 0, "R1");

        // R4 inactive request
        ask(0, 0, 2'b10, 7'h00, "R4 idle");
        status(0, 0, 0, "R4");

        // R10 move mode, R7 record end
        issue(10, 0, 0, 0, 0);
        ask(0, 0, 2'b00, 7'h41, "R10 wm kept");
        ask(0, 0, 2'b00, 7'h05, "R10 plain");
        ask(0, 0, 2'b01, 7'h00, "R7 group mark");
        status(0, 1, 13, "R7");

        // R2 no request -> no strobe
        @(negedge clk);
        check(rsp_valid == 0, "R2 idle no strobe", rsp_valid, 0);

        // R12 six-bit
        issue(20, 0, 0, 1, 0);
        ask(0, 0, 2'b00, 7'h07, "R12 stripped");

        // R7 no-record passes group mark
        issue(30, 0, 1, 0, 0);
        ask(0, 0, 2'b00, 7'h7F, "R7 norec data");
        status(1, 0, 31, "R7 norec");

        // R8 load expansion
        issue(40, 1, 0, 0, 0);
        ask(0, 0, 2'b00, 7'h1D, "R8 sep wm");
        ask(0, 0, 2'b00, 7'h12, "R8 held wm");
        status(1, 0, 41, "R8 no fetch on held");
        ask(0, 0, 2'b00, 7'h1D, "R8 sep of 035");
        ask(0, 0, 2'b00, 7'h1D, "R8 held 035");
        ask(0, 0, 2'b00, 7'h03, "R8 plain");
        ask(0, 0, 2'b01, 7'h00, "R8 end");

        // R5 disk command phase
        issue(50, 0, 0, 0, 1);
        ask(0, 0, 2'b00, 7'h05, "R5 masked");
        ask(0, 0, 2'b00, 7'h07, "R5 plain");
        ask(0, 0, 2'b01, 7'h00, "R5 terminator");
        ask(0, 0, 2'b01, 7'h00, "R5 terminator again");
        status(1, 0, 52, "R5");

        // R3 write-end flag
        issue(60, 0, 0, 0, 0);
        ask(1, 0, 2'b01, 7'h00, "R3 weor");
        check(done_o == 1, "R3 done", done_o, 1);

        // R9 device end-of-record
        issue(70, 0, 0, 0, 0);
        ask(0, 1, 2'b01, 7'h00, "R9 reor");
        status(0, 1, 71, "R9");

        // R6 memory overrun
        issue(510, 0, 1, 0, 0);
        ask(0, 0, 2'b00, 7'h11, "R6 before last");
        ask(0, 0, 2'b01, 7'h00, "R6 overrun");
        status(0, 0, 512, "R6");

        // R11 new command discards held char
        issue(40, 1, 0, 0, 0);
        ask(0, 0, 2'b00, 7'h1D, "R11 sep");
        issue(42, 1, 0, 0, 0);
        ask(0, 0, 2'b00, 7'h03, "R11 hold dropped");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2 queue drained", q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule